// File: doc/BRIEF.md
# Timer Interrupt Status Latch

This block watches the outputs of two counter channels of a programmable interval timer, channel 0 and channel 2. A rising transition on either output sets a status bit that stays set. Both bits appear on a status port, so an interrupt handler can tell which channel fired. The two bits are ORed into one interrupt request line that goes to the interrupt controller. Software acknowledges a channel by writing a 0 into that channel's bit position. Writing a 1 leaves the bit alone, so one channel can be cleared without disturbing the other.

The timer outputs are asynchronous to the block clock. Each one passes through a two-stage synchronizer. A small two-state level tracker per channel then turns the synchronized level into a single-cycle rise pulse. The tracker has two states:

- `LVL_LOW`: the level was last seen low. It moves to `LVL_HIGH` when the synchronized level is high, and that transition is the rise event.
- `LVL_HIGH`: the level was last seen high. It moves back to `LVL_LOW` when the level is low.

Because the tracker waits in `LVL_HIGH`, a level that stays high produces only one event.

A prescaler divides the block clock to give a one-cycle tick at the counter clock rate. With the default divide ratio of 20 and a 5 MHz clock, the tick is 250 kHz, a 4 µs period. In the surrounding system, channel 0's output also clocks channel 1, which chains the two counters.

Top module: `tis_top`

## Requirements
- R1: After reset, `status` reads 0x00, `irq` is 0 and no tick is pending.
- R2: A low-to-high transition on `tmr_ch0_out` sets status bit 0. A low-to-high transition on `tmr_ch2_out` sets status bit 1. The bit becomes visible on the third rising clock edge after the input changes: two synchronizer stages, then the status register.
- R3: An input that stays high does not set its bit again after the bit has been cleared.
- R4: A cycle with `wr_en` high clears status bit 0 when `wr_data[0]` is 0 and clears status bit 1 when `wr_data[1]` is 0. A 1 in either position leaves that bit unchanged. The result is visible on the next clock edge.
- R5: `irq` is 1 exactly when status bit 0 or status bit 1 is set.
- R6: If a rise event and a clearing write for the same bit fall on the same clock edge, the bit ends up set.
- R7: Status bits 7 down to 2 always read 0, whatever is written to them.
- R8: `tmr_tick` is a pulse one clock wide. It recurs every `TICK_DIV` clocks, and the first pulse comes `TICK_DIV`-1 clocks after reset is released.
- R9: A high-to-low transition on a timer output leaves its status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ch0_out | input | 1 | Output of counter channel 0 (asynchronous) |
| tmr_ch2_out | input | 1 | Output of counter channel 2 (asynchronous) |
| wr_en | input | 1 | Write strobe for the status port |
| wr_data | input | STAT_W | Write data; a 0 in bit 0 or bit 1 clears that status bit |
| status | output | STAT_W | Status port: bit 0 is channel 0, bit 1 is channel 2, the rest are 0 |
| irq | output | 1 | Timer interrupt request |
| tmr_tick | output | 1 | Counter clock tick, one cycle every TICK_DIV clocks |

## Verification
The assertions check the following on every cycle:
- a synchronized rise always sets its bit;
- a clear takes effect only when no rise event competes with it;
- a set bit survives any cycle that carries no clearing write;
- a clear bit stays clear without a rise event;
- the tick spacing is right.

Some behaviours only the bench scenarios can show:
- the three-edge latency from the raw pin;
- that a clear with the input still held high stays cleared;
- a falling edge doing nothing;
- the same-cycle tie between a rise and a clear;
- simultaneous rises on both channels;
- writes that carry 1s in the unused positions.

// File: rtl/tis_pkg.sv
package tis_pkg;
    // Level tracker states for one timer channel
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/tis_sync.sv
module tis_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/tis_edge_fsm.sv
module tis_edge_fsm
    import tis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    lvl_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LVL_LOW;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            LVL_LOW:  if (lvl)  nxt = LVL_HIGH;
            LVL_HIGH: if (!lvl) nxt = LVL_LOW;
        endcase
    end

    // Rise event: leaving LVL_LOW towards LVL_HIGH
    always_comb begin
        rise = 1'b0;
        unique case (state)
            LVL_LOW:  rise = lvl;
            LVL_HIGH: rise = 1'b0;
        endcase
    end
endmodule

// File: rtl/tis_prescaler.sv
module tis_prescaler #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/tis_top.sv
module tis_top #(
    parameter int STAT_W   = 8,
    parameter int TICK_DIV = 20,
    parameter int SYNC_FF  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_ch0_out,
    input  logic              tmr_ch2_out,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              tmr_tick
);
    localparam int NCH = 2;

    logic [NCH-1:0] pin_in;
    logic [NCH-1:0] lvl_sync;
    logic [NCH-1:0] rise_ev;
    logic [NCH-1:0] stat_q;

    assign pin_in = {tmr_ch2_out, tmr_ch0_out};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tis_sync #(.STAGES(SYNC_FF)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pin_in[i]),
            .q    (lvl_sync[i])
        );

        tis_edge_fsm u_fsm (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl_sync[i]),
            .rise (rise_ev[i])
        );

        // A rise event takes priority over a clearing write
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     stat_q[i] <= 1'b0;
            else if (rise_ev[i])            stat_q[i] <= 1'b1;
            else if (wr_en && !wr_data[i])  stat_q[i] <= 1'b0;
        end
    end

    tis_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tmr_tick)
    );

    assign status = {{(STAT_W-NCH){1'b0}}, stat_q};
    assign irq    = |stat_q;
endmodule

// File: rtl/tis_top_sva.sv
module tis_top_sva #(
    parameter int STAT_W   = 8,
    parameter int TICK_DIV = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        lvl,
    input logic [1:0]        stat,
    input logic              wr_en,
    input logic [STAT_W-1:0] wr_data,
    input logic              tick
);
    localparam int GW = $clog2(TICK_DIV + 1);

    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    gap <= '0;
        else if (tick) gap <= '0;
        else           gap <= gap + 1'b1;
    end

    // R2: a synchronized rise sets channel 0's bit
    a_r2_set_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl[0]) |=> stat[0]);

    // R2: a synchronized rise sets channel 2's bit
    a_r2_set_ch2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl[1]) |=> stat[1]);

    // R4: a clearing write with no competing rise clears the bit
    a_r4_clear_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0] && !$rose(lvl[0])) |=> !stat[0]);

    // R4: a set bit is kept unless it is cleared by a write
    a_r4_keep_ch2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[1] && !(wr_en && !wr_data[1])) |=> stat[1]);

    // R3: without a rise event a clear bit stays clear
    a_r3_no_reset_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat[0] && !$rose(lvl[0])) |=> !stat[0]);

    // R8: the tick pulse is one cycle wide
    a_r8_tick_width: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8: the tick comes at the expected spacing
    a_r8_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap == GW'(TICK_DIV - 1)));
endmodule

bind tis_top tis_top_sva #(.STAT_W(STAT_W), .TICK_DIV(TICK_DIV)) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (lvl_sync),
    .stat   (stat_q),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .tick   (tmr_tick)
);

// File: tb/tis_top_tb.sv
module tis_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STAT_W     = 8;
    localparam int TICK_DIV   = 20;

    typedef struct {
        logic [STAT_W-1:0] exp_stat;
        logic              exp_irq;
        string             tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ch0 = 1'b0;
    logic              ch2 = 1'b0;
    logic              wr_en = 1'b0;
    logic [STAT_W-1:0] wr_data = '0;
    logic [STAT_W-1:0] status;
    logic              irq;
    logic              tmr_tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tis_top #(.STAT_W(STAT_W), .TICK_DIV(TICK_DIV)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_ch0_out(ch0),
        .tmr_ch2_out(ch2),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .status     (status),
        .irq        (irq),
        .tmr_tick   (tmr_tick)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [STAT_W-1:0] s, input string tag);
        sb_item_t it;
        it.exp_stat = s;
        it.exp_irq  = |s[1:0];
        it.tag      = tag;
        sb_q.push_back(it);
    endtask

    task automatic write_reg(input logic [STAT_W-1:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        cyc(1);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: compare outputs against queued expectations
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #1;
            while (sb_q.size() != 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (status !== it.exp_stat || irq !== it.exp_irq) begin
                    errors++;
                    $display("FAIL %s: actual status=%02h irq=%b expected status=%02h irq=%b",
                             it.tag, status, irq, it.exp_stat, it.exp_irq);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t_first;
        int t_second;
        int n_tick;
        bit wide;

        cyc(3);
        rst_n = 1'b1;
        expect_out(8'h00, "R1 reset state");
        check(tmr_tick === 1'b0, "R1 no tick at reset", tmr_tick, 0);

        // R2 and R5: channel 0 rise sets bit 0 after three edges
        ch0 = 1'b1;
        cyc(2);
        expect_out(8'h00, "R2 ch0 not yet visible");
        cyc(1);
        expect_out(8'h01, "R2 ch0 set, R5 irq");

        // R4: clear bit 0 while ch0 stays high; R3: no new set
        write_reg(8'hFE);
        expect_out(8'h00, "R4 clear bit0");
        cyc(6);
        expect_out(8'h00, "R3 steady high no re-set");

        // R9: falling edge does nothing
        ch0 = 1'b0;
        cyc(5);
        expect_out(8'h00, "R9 fall ignored");

        // R2: channel 2 sets bit 1
        ch2 = 1'b1;
        cyc(3);
        expect_out(8'h02, "R2 ch2 set");

        // channel 0 again, both set
        ch0 = 1'b1;
        cyc(3);
        expect_out(8'h03, "R2 both bits set R5");

        // R4: clear only bit 0, bit 1 kept
        write_reg(8'hFE);
        expect_out(8'h02, "R4 selective clear");

        // R7 and R4: writing ones changes nothing, upper bits stay 0
        write_reg(8'hFF);
        expect_out(8'h02, "R7 unused bits zero R4 ones kept");

        write_reg(8'h00);
        expect_out(8'h00, "R4 clear all R5 irq low");

        // R6: rise and clear on the same edge
        ch0 = 1'b0;
        ch2 = 1'b0;
        cyc(4);
        ch0 = 1'b1;
        cyc(2);
        wr_en   = 1'b1;
        wr_data = 8'h00;
        cyc(1);
        wr_en   = 1'b0;
        expect_out(8'h01, "R6 edge wins over clear");

        write_reg(8'h00);
        expect_out(8'h00, "R4 clear after R6");

        // Simultaneous rises on both channels
        ch0 = 1'b0;
        cyc(4);
        ch0 = 1'b1;
        ch2 = 1'b1;
        cyc(3);
        expect_out(8'h03, "R2 simultaneous rises");
        cyc(1);

        // R8: tick spacing and width
        t_first  = -1;
        t_second = -1;
        n_tick   = 0;
        wide     = 1'b0;
        for (int k = 0; k < 3 * TICK_DIV; k++) begin
            cyc(1);
            if (tmr_tick === 1'b1) begin
                if (n_tick > 0 && t_second < 0 && k == t_first + 1) wide = 1'b1;
                if (t_first < 0) t_first = k;
                else if (t_second < 0) t_second = k;
                n_tick++;
            end
        end
        check(t_first >= 0 && t_second >= 0, "R8 ticks seen", n_tick, 2);
        check((t_second - t_first) == TICK_DIV, "R8 tick period", t_second - t_first, TICK_DIV);
        check(!wide, "R8 tick one cycle wide", wide, 0);

        cyc(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule